// File: doc/BRIEF.md
# Image Task Sequencing Controller

This controller drives a chain of image-processing passes over a picture that already sits in external memory. When the start command arrives, it reads a three-word descriptor from a small configuration memory. The descriptor holds the result image size, where the result lives in memory, and a short list of task codes with a count. The controller then hands the tasks to a processing unit one at a time. Each task goes out over a valid/ready channel together with the current parameter set: height, width, start address and bank.

When the unit finishes a task, it pulses a completion strobe carrying a rewritten parameter set. That set replaces the current one, and the next task is dispatched with it. Once the task count is used up, the controller streams word addresses covering the final image under a valid/ready handshake, so that the result can be read out toward the host. It then returns to idle. The start command is meant to be raised only after acquisition has finished writing the image to memory.

Top module: `img_task_seq`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `cfg_req_o`, `task_valid_o` and `out_valid_o` are all low.
- R2: A start seen while idle makes exactly three configuration reads, at `cfg_base_i`, `cfg_base_i+1` and `cfg_base_i+2`, in that order. Each read waits one cycle for its data before the next is issued, so a request is never high on two consecutive cycles. A start raised while busy is ignored.
- R3: Descriptor word 0 (size) holds width in bits [11:0] and height in bits [23:12]. Word 1 (placement) holds the start address in bits [19:0] and the bank in bits [21:20]. Word 2 (tasks) holds four 2-bit codes, with entry i in bits [2i+1:2i] (entry 0 is dispatched first), and the task count in bits [10:8].
- R4: Tasks are dispatched one at a time, in list order. `task_valid_o` stays high with a stable code and stable parameters until `task_ready_i`. The next task is offered only after `done_valid_i` for the previous one.
- R5: The first task receives the parameters from the descriptor. Every later task, and the output phase, uses the parameters returned with the most recent `done_valid_i`.
- R6: A task count of zero skips dispatch and goes straight to output with the descriptor parameters. A count above four behaves as four.
- R7: Output address i equals start + bank×2^18 + i, modulo 2^24, for i from 0 to height×floor(width/4)−1, in increasing order. Each address is held until `out_ready_i`.
- R8: If height×floor(width/4) is zero, no output address is produced and the controller returns to idle.
- R9: `busy_o` rises on the cycle after the start is taken, stays high through the whole job, and falls on the cycle after the last address is accepted.
- R10: At most one of `cfg_req_o`, `task_valid_o` and `out_valid_o` is high in any cycle, and none of them is high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command, image is in memory |
| cfg_base_i | input | 4 | Descriptor base address in configuration memory |
| cfg_req_o | output | 1 | Configuration read request |
| cfg_addr_o | output | 4 | Configuration read address |
| cfg_rdata_i | input | 24 | Configuration read data, valid one cycle after request |
| task_valid_o | output | 1 | Task offered to processing unit |
| task_ready_i | input | 1 | Processing unit accepts the task |
| task_code_o | output | 2 | Selected task code |
| task_height_o | output | 12 | Current height |
| task_width_o | output | 12 | Current width |
| task_start_o | output | 20 | Current start address |
| task_bank_o | output | 2 | Current bank |
| done_valid_i | input | 1 | Task finished, returned parameters valid |
| done_height_i | input | 12 | Returned height |
| done_width_i | input | 12 | Returned width |
| done_start_i | input | 20 | Returned start address |
| done_bank_i | input | 2 | Returned bank |
| out_valid_o | output | 1 | Output address valid |
| out_ready_i | input | 1 | Output address accepted |
| out_addr_o | output | 24 | Output word address |
| busy_o | output | 1 | Job in progress |

## Verification
Jobs are run with random descriptors, task lists and counts, and with random stalls on the task-ready, completion and output-ready sides. This separates correct parameter carry-over between tasks from reuse of the original descriptor, because every task code returns a visibly different set: a narrower width, swapped dimensions, a moved start or a next bank. Directed jobs cover a count of zero, counts of five and seven, which tell clamping apart from wrap, and zero-height or narrow images, which must produce no addresses. They also cover the top bank with a high start address, which checks the offset arithmetic, and a start pulse in mid-job, which must not add configuration reads.

// File: rtl/img_seq_pkg.sv
package img_seq_pkg;
  localparam int unsigned DIM_W   = 12;
  localparam int unsigned ADDR_W  = 20;
  localparam int unsigned BANK_W  = 2;
  localparam int unsigned CODE_W  = 2;
  localparam int unsigned LIST_N  = 4;
  localparam int unsigned CNT_W   = 3;
  localparam int unsigned WORD_W  = 2 * DIM_W;
  localparam int unsigned LIST_W  = LIST_N * CODE_W;
  localparam int unsigned TWORD_W = LIST_W + CNT_W;
  localparam int unsigned NFETCH  = 3;
  localparam int unsigned FIDX_W  = 2;
  localparam int unsigned TIDX_W  = $clog2(LIST_N);

  typedef struct packed {
    logic [DIM_W-1:0]  height;
    logic [DIM_W-1:0]  width;
    logic [ADDR_W-1:0] start;
    logic [BANK_W-1:0] bank;
  } par_t;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_DISP, S_RUN, S_OUT
  } st_e;
endpackage

// File: rtl/img_seq_par_reg.sv
module img_seq_par_reg
  import img_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_size_i,
  input  logic              ld_place_i,
  input  logic              ld_ret_i,
  input  logic [WORD_W-1:0] cfg_data_i,
  input  par_t              ret_i,
  output par_t              par_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o <= '0;
    end else if (ld_ret_i) begin
      par_o <= ret_i;
    end else begin
      if (ld_size_i) begin
        par_o.width  <= cfg_data_i[DIM_W-1:0];
        par_o.height <= cfg_data_i[2*DIM_W-1:DIM_W];
      end
      if (ld_place_i) begin
        par_o.start <= cfg_data_i[ADDR_W-1:0];
        par_o.bank  <= cfg_data_i[ADDR_W +: BANK_W];
      end
    end
  end
endmodule

// File: rtl/img_seq_addr_gen.sv
module img_seq_addr_gen
  import img_seq_pkg::*;
#(
  parameter int unsigned OUT_AW  = 24,
  parameter int unsigned BANK_SH = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  par_t              par_i,
  output logic [OUT_AW-1:0] addr_o,
  output logic              last_o,
  output logic              empty_o
);
  localparam int unsigned IDX_W = 2 * DIM_W;

  logic [IDX_W-1:0] idx_q, total;

  // four pixels per word
  assign total   = IDX_W'(par_i.height) * IDX_W'(par_i.width >> 2);
  assign empty_o = (total == '0);
  assign last_o  = (idx_q == total - IDX_W'(1));
  assign addr_o  = OUT_AW'(par_i.start) + (OUT_AW'(par_i.bank) << BANK_SH) + OUT_AW'(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (adv_i) idx_q <= idx_q + IDX_W'(1);
  end
endmodule

// File: rtl/img_seq_ctrl.sv
module img_seq_ctrl
  import img_seq_pkg::*;
#(
  parameter int unsigned CFG_AW = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CFG_AW-1:0]  cfg_base_i,
  output logic               cfg_req_o,
  output logic [CFG_AW-1:0]  cfg_addr_o,
  input  logic [TWORD_W-1:0] task_word_i,
  output logic               ld_size_o,
  output logic               ld_place_o,
  output logic               task_valid_o,
  input  logic               task_ready_i,
  output logic [CODE_W-1:0]  task_code_o,
  input  logic               done_valid_i,
  output logic               ld_ret_o,
  input  logic               gen_empty_i,
  input  logic               gen_last_i,
  input  logic               out_ready_i,
  output logic               out_valid_o,
  output logic               gen_clr_o,
  output logic               gen_adv_o,
  output logic               busy_o
);
  st_e               st_q, st_d;
  logic [FIDX_W-1:0] fidx_q;
  logic [LIST_W-1:0] list_q;
  logic [CNT_W-1:0]  cnt_q, tidx_q, cnt_raw, cnt_new;
  logic [CODE_W-1:0] codes [LIST_N];
  logic              last_fetch, last_task;

  for (genvar i = 0; i < LIST_N; i++) begin : g_codes
    assign codes[i] = list_q[i*CODE_W +: CODE_W];
  end

  assign cnt_raw    = task_word_i[LIST_W +: CNT_W];
  assign cnt_new    = (cnt_raw > CNT_W'(LIST_N)) ? CNT_W'(LIST_N) : cnt_raw;
  assign last_fetch = (fidx_q == FIDX_W'(NFETCH - 1));
  assign last_task  = (tidx_q + CNT_W'(1) == cnt_q);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (start_i) st_d = S_REQ;
      S_REQ:  st_d = S_WAIT;
      S_WAIT: begin
        if (!last_fetch)          st_d = S_REQ;
        else if (cnt_new == '0)   st_d = S_OUT;
        else                      st_d = S_DISP;
      end
      S_DISP: if (task_ready_i) st_d = S_RUN;
      S_RUN:  if (done_valid_i) st_d = last_task ? S_OUT : S_DISP;
      S_OUT:  if (gen_empty_i || (out_ready_i && gen_last_i)) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      fidx_q <= '0;
      list_q <= '0;
      cnt_q  <= '0;
      tidx_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE) fidx_q <= '0;
      else if (st_q == S_WAIT) fidx_q <= fidx_q + FIDX_W'(1);
      if (st_q == S_WAIT && last_fetch) begin
        list_q <= task_word_i[LIST_W-1:0];
        cnt_q  <= cnt_new;
        tidx_q <= '0;
      end else if (st_q == S_RUN && done_valid_i) begin
        tidx_q <= tidx_q + CNT_W'(1);
      end
    end
  end

  assign cfg_req_o    = (st_q == S_REQ);
  assign cfg_addr_o   = cfg_base_i + CFG_AW'(fidx_q);
  assign ld_size_o    = (st_q == S_WAIT) && (fidx_q == FIDX_W'(0));
  assign ld_place_o   = (st_q == S_WAIT) && (fidx_q == FIDX_W'(1));
  assign task_valid_o = (st_q == S_DISP);
  assign task_code_o  = codes[tidx_q[TIDX_W-1:0]];
  assign ld_ret_o     = (st_q == S_RUN) && done_valid_i;
  assign out_valid_o  = (st_q == S_OUT) && !gen_empty_i;
  assign gen_clr_o    = (st_q != S_OUT);
  assign gen_adv_o    = out_valid_o && out_ready_i;
  assign busy_o       = (st_q != S_IDLE);
endmodule

// File: rtl/img_task_seq.sv
module img_task_seq
  import img_seq_pkg::*;
#(
  parameter int unsigned CFG_AW  = 4,
  parameter int unsigned OUT_AW  = 24,
  parameter int unsigned BANK_SH = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CFG_AW-1:0] cfg_base_i,
  output logic              cfg_req_o,
  output logic [CFG_AW-1:0] cfg_addr_o,
  input  logic [WORD_W-1:0] cfg_rdata_i,
  output logic              task_valid_o,
  input  logic              task_ready_i,
  output logic [CODE_W-1:0] task_code_o,
  output logic [DIM_W-1:0]  task_height_o,
  output logic [DIM_W-1:0]  task_width_o,
  output logic [ADDR_W-1:0] task_start_o,
  output logic [BANK_W-1:0] task_bank_o,
  input  logic              done_valid_i,
  input  logic [DIM_W-1:0]  done_height_i,
  input  logic [DIM_W-1:0]  done_width_i,
  input  logic [ADDR_W-1:0] done_start_i,
  input  logic [BANK_W-1:0] done_bank_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [OUT_AW-1:0] out_addr_o,
  output logic              busy_o
);
  logic ld_size, ld_place, ld_ret;
  logic gen_clr, gen_adv, gen_last, gen_empty;
  par_t par_q, ret;

  assign ret = '{height: done_height_i, width: done_width_i,
                 start: done_start_i, bank: done_bank_i};

  img_seq_ctrl #(.CFG_AW(CFG_AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .cfg_base_i   (cfg_base_i),
    .cfg_req_o    (cfg_req_o),
    .cfg_addr_o   (cfg_addr_o),
    .task_word_i  (cfg_rdata_i[TWORD_W-1:0]),
    .ld_size_o    (ld_size),
    .ld_place_o   (ld_place),
    .task_valid_o (task_valid_o),
    .task_ready_i (task_ready_i),
    .task_code_o  (task_code_o),
    .done_valid_i (done_valid_i),
    .ld_ret_o     (ld_ret),
    .gen_empty_i  (gen_empty),
    .gen_last_i   (gen_last),
    .out_ready_i  (out_ready_i),
    .out_valid_o  (out_valid_o),
    .gen_clr_o    (gen_clr),
    .gen_adv_o    (gen_adv),
    .busy_o       (busy_o)
  );

  img_seq_par_reg u_par (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_size_i  (ld_size),
    .ld_place_i (ld_place),
    .ld_ret_i   (ld_ret),
    .cfg_data_i (cfg_rdata_i),
    .ret_i      (ret),
    .par_o      (par_q)
  );

  img_seq_addr_gen #(.OUT_AW(OUT_AW), .BANK_SH(BANK_SH)) u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (gen_clr),
    .adv_i   (gen_adv),
    .par_i   (par_q),
    .addr_o  (out_addr_o),
    .last_o  (gen_last),
    .empty_o (gen_empty)
  );

  assign task_height_o = par_q.height;
  assign task_width_o  = par_q.width;
  assign task_start_o  = par_q.start;
  assign task_bank_o   = par_q.bank;
endmodule

// File: rtl/img_task_seq_chk.sv
module img_task_seq_chk #(
  parameter int unsigned OUT_AW = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_req_o,
  input logic              task_valid_o,
  input logic              task_ready_i,
  input logic [1:0]        task_code_o,
  input logic [45:0]       task_par,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [OUT_AW-1:0] out_addr_o,
  input logic              busy_o
);
  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cfg_req_o && !task_valid_o && !out_valid_o);

  a_r2_req_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |=> !cfg_req_o);

  a_r9_busy_starts_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> cfg_req_o);

  a_r4_task_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_valid_o && !task_ready_i |=>
      task_valid_o && $stable(task_code_o) && $stable(task_par));

  a_r7_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o));

  a_r7_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |=>
      !out_valid_o || (out_addr_o == $past(out_addr_o) + OUT_AW'(1)));

  a_r10_one_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_req_o, task_valid_o, out_valid_o}));
endmodule

bind img_task_seq img_task_seq_chk #(.OUT_AW(OUT_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_req_o    (cfg_req_o),
  .task_valid_o (task_valid_o),
  .task_ready_i (task_ready_i),
  .task_code_o  (task_code_o),
  .task_par     ({task_height_o, task_width_o, task_start_o, task_bank_o}),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_addr_o   (out_addr_o),
  .busy_o       (busy_o)
);

// File: tb/img_task_seq_test.sv
module img_task_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfg_base = '0;
  logic        cfg_req;
  logic [3:0]  cfg_addr;
  logic [23:0] cfg_rdata = '0;
  logic        task_valid, task_ready = 1'b0;
  logic [1:0]  task_code;
  logic [11:0] t_h, t_w;
  logic [19:0] t_s;
  logic [1:0]  t_b;
  logic        done_valid = 1'b0;
  logic [11:0] d_h = '0, d_w = '0;
  logic [19:0] d_s = '0;
  logic [1:0]  d_b = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [23:0] out_addr;
  logic        busy;
  logic [23:0] mem [16];
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (cfg_req) cfg_rdata <= mem[cfg_addr];

  img_task_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_base_i(cfg_base),
    .cfg_req_o(cfg_req), .cfg_addr_o(cfg_addr), .cfg_rdata_i(cfg_rdata),
    .task_valid_o(task_valid), .task_ready_i(task_ready), .task_code_o(task_code),
    .task_height_o(t_h), .task_width_o(t_w), .task_start_o(t_s), .task_bank_o(t_b),
    .done_valid_i(done_valid), .done_height_i(d_h), .done_width_i(d_w),
    .done_start_i(d_s), .done_bank_i(d_b),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_addr_o(out_addr),
    .busy_o(busy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench model of what each unit returns
  function automatic logic [45:0] next_par(input logic [1:0] code, input logic [45:0] p);
    logic [11:0] h = p[45:34], w = p[33:22];
    logic [19:0] s = p[21:2];
    logic [1:0]  b = p[1:0];
    case (code)
      2'd0: if (w >= 12'd8) w = w - 12'd4;
      2'd1: begin h = p[33:22]; w = p[45:34]; end
      2'd2: s = s + 20'h40;
      default: b = b + 2'd1;
    endcase
    return {h, w, s, b};
  endfunction

  function automatic int words_of(input logic [45:0] p);
    return int'(p[45:34]) * int'(p[33:22] >> 2);
  endfunction

  task automatic run_job(input logic [3:0] base, input logic [11:0] h, input logic [11:0] w,
                         input logic [19:0] s, input logic [1:0] b, input logic [7:0] list,
                         input logic [2:0] cnt, input bit poke);
    logic [45:0] par = {h, w, s, b};
    int ncfg = 0, ntask = 0, nword = 0, dly = 0, cyc = 0;
    int eff = (cnt > 3'd4) ? 4 : int'(cnt);
    bit pend = 0;
    mem[base]      = {h, w};
    mem[base + 4'd1] = {2'b0, b, s};
    mem[base + 4'd2] = {13'b0, cnt, list};
    cfg_base = base;
    start = 1'b1;
    @(negedge clk);
    chk("R9 busy after start", busy, 1);
    while (busy && cyc < 5000) begin
      start = poke && (cyc == 3);
      task_ready = 0; done_valid = 0; out_ready = 0;
      if (cfg_req) begin
        chk("R2 read address", cfg_addr, base + 4'(ncfg));
        ncfg++;
      end
      if (task_valid) begin
        if (!pend && ($urandom % 2 == 0)) begin
          chk("R4 task code order", task_code, list[2*ntask +: 2]);
          chk("R5 task params", {t_h, t_w, t_s, t_b}, par);
          task_ready = 1; pend = 1; dly = int'($urandom % 3);
        end
      end else if (pend) begin
        if (dly == 0) begin
          par = next_par(list[2*ntask +: 2], par);
          {d_h, d_w, d_s, d_b} = par;
          done_valid = 1; pend = 0; ntask++;
        end else dly--;
      end
      if (out_valid) begin
        out_ready = ($urandom % 4 != 0);
        if (out_ready) begin
          chk("R7 output address", out_addr, 24'(par[21:2]) + (24'(par[1:0]) << 18) + 24'(nword));
          nword++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    start = 0; task_ready = 0; done_valid = 0; out_ready = 0;
    chk("R9 busy falls after last word", 64'(cyc < 5000), 1);
    chk("R2 exactly three reads", ncfg, 3);
    chk("R6 tasks dispatched", ntask, eff);
    chk("R7 R8 word count", nword, words_of(par));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {busy, cfg_req, task_valid, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {busy, cfg_req, task_valid, out_valid}, 0);
    // R6 zero count, R3 field layout
    run_job(4'd0, 12'd3, 12'd8, 20'h00100, 2'd1, 8'hE4, 3'd0, 0);
    // R4 full list of four
    run_job(4'd4, 12'd2, 12'd16, 20'h00200, 2'd0, 8'h1B, 3'd4, 0);
    // R6 clamp above four
    run_job(4'd8, 12'd2, 12'd12, 20'h00300, 2'd2, 8'h93, 3'd5, 0);
    run_job(4'd1, 12'd1, 12'd20, 20'h00040, 2'd0, 8'h6C, 3'd7, 0);
    // R8 empty images
    run_job(4'd2, 12'd0, 12'd16, 20'h00010, 2'd0, 8'h00, 3'd0, 0);
    run_job(4'd3, 12'd5, 12'd3, 20'h00020, 2'd0, 8'h08, 3'd1, 0);
    // R7 top bank and high start
    run_job(4'd12, 12'd2, 12'd8, 20'hFFFFE, 2'd3, 8'h00, 3'd0, 0);
    // R2 start while busy is ignored
    run_job(4'd5, 12'd2, 12'd8, 20'h00500, 2'd1, 8'h27, 3'd3, 1);
    for (int j = 0; j < 25; j++) begin
      run_job(4'($urandom % 14), 12'(1 + $urandom % 6), 12'($urandom % 21),
              20'($urandom), 2'($urandom), 8'($urandom), 3'($urandom % 6), bit'($urandom % 2));
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule